// File: doc/BRIEF.md
# Vector Length Setting Unit

This block carries out a set-vector-length operation in one issue cycle. The caller supplies three things: an immediate that bounds the request, a flag that marks the source register as the hard-wired zero register, and the value read from the source register. From these the block works out a new vector length (VL) and returns it in the same cycle as the value to write to the destination register. The internal VL register takes the new value on the next clock edge.

The result does not clamp the request to the immediate. When the source register is the zero register, the immediate itself becomes the length. A request larger than twice the immediate selects the full XLEN. A request above the immediate, but not above twice it, is halved and rounded down. Any smaller request passes through unchanged. An immediate greater than XLEN is illegal. It raises a trap pulse and leaves both VL and the destination write untouched. The trap check takes priority over every other rule.

Top module: `vlset_unit`

## Requirements
- R1: After reset `vl_o` reads 0, and `trap_o` and `rd_we_o` are low while no request is presented.
- R2: A request with `imm_i` greater than XLEN raises `trap_o` in the same cycle and holds `rd_we_o` low. `vl_o` keeps its old value, even when `src_zero_i` is set.
- R3: A legal request with `src_zero_i` = 1 sets the new VL to `imm_i`, whatever `src_val_i` holds.
- R4: Otherwise, when `src_val_i` is strictly greater than 2*`imm_i`, the new VL is XLEN.
- R5: Otherwise, when `src_val_i` is strictly greater than `imm_i`, the new VL is `src_val_i` shifted right by one (floor of half).
- R6: Otherwise (`src_val_i` <= `imm_i`), the new VL equals `src_val_i`.
- R7: For a legal request, `rd_we_o` is high and `rd_val_o` equals the new VL in the request cycle, and `vl_o` shows that value from the following clock edge onward.
- R8: When `req_valid_i` is low, `vl_o` keeps its value and `trap_o` and `rd_we_o` stay low.
- R9: The twice-immediate comparison is made one bit wider than XLEN, so that `imm_i` = XLEN with XLEN < `src_val_i` <= 2*XLEN gives the halved value rather than XLEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A set-length request is present this cycle |
| imm_i | input | IMM_W ($clog2(XLEN+2)) | Immediate length bound |
| src_zero_i | input | 1 | Source register is the zero register |
| src_val_i | input | XLEN | Source register value (requested length) |
| trap_o | output | 1 | Illegal immediate, one-cycle pulse with the request |
| rd_we_o | output | 1 | Destination register write enable |
| rd_val_o | output | XLEN | Value to write to the destination register (new VL) |
| vl_o | output | VL_W ($clog2(XLEN+1)) | Current registered vector length |

## Verification
The bench builds the block with the default XLEN of 64, which makes the immediate 7 bits wide. At that width the first illegal value (65) and the largest encodable value (127) can both be driven, so the trap path is reachable. It also allows `imm_i` = 64, where the doubled immediate (128) does not fit in the immediate's own width. That case shows whether the wide comparison is present. The 64-bit source lets all-ones requests and the exact boundaries at the immediate and at twice the immediate be driven alongside the zero-register case.

// File: rtl/vlset_pkg.sv
package vlset_pkg;

    // Which rule produced the new vector length, in priority order.
    typedef enum logic [2:0] {
        RULE_TRAP = 3'd0,
        RULE_IMM  = 3'd1,
        RULE_FULL = 3'd2,
        RULE_HALF = 3'd3,
        RULE_PASS = 3'd4
    } vl_rule_e;

endpackage

// File: rtl/vlset_classify.sv
module vlset_classify
    import vlset_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = $clog2(XLEN + 2)
) (
    input  logic [IMM_W-1:0] imm_i,
    input  logic             src_zero_i,
    input  logic [XLEN-1:0]  src_val_i,
    output vl_rule_e         rule_o
);

    // One extra bit so that doubling the immediate cannot wrap.
    localparam int CMP_W = XLEN + 1;

    logic [CMP_W-1:0] imm_w;
    logic [CMP_W-1:0] imm_dbl;
    logic [CMP_W-1:0] src_w;

    always_comb begin
        imm_w   = CMP_W'(imm_i);
        imm_dbl = imm_w << 1;
        src_w   = CMP_W'(src_val_i);

        if (imm_w > CMP_W'(XLEN)) begin
            rule_o = RULE_TRAP;
        end else if (src_zero_i) begin
            rule_o = RULE_IMM;
        end else if (src_w > imm_dbl) begin
            rule_o = RULE_FULL;
        end else if (src_w > imm_w) begin
            rule_o = RULE_HALF;
        end else begin
            rule_o = RULE_PASS;
        end
    end

endmodule

// File: rtl/vlset_select.sv
module vlset_select
    import vlset_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = $clog2(XLEN + 2),
    parameter int VL_W  = $clog2(XLEN + 1)
) (
    input  vl_rule_e         rule_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [XLEN-1:0]  src_val_i,
    output logic [VL_W-1:0]  vl_new_o
);

    logic [XLEN-1:0] src_half;

    always_comb begin
        src_half = src_val_i >> 1;
        unique case (rule_i)
            RULE_IMM:  vl_new_o = VL_W'(imm_i);
            RULE_FULL: vl_new_o = VL_W'(XLEN);
            RULE_HALF: vl_new_o = VL_W'(src_half);
            RULE_PASS: vl_new_o = VL_W'(src_val_i);
            default:   vl_new_o = '0;
        endcase
    end

endmodule

// File: rtl/vlset_unit.sv
module vlset_unit
    import vlset_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = $clog2(XLEN + 2),
    parameter int VL_W  = $clog2(XLEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             src_zero_i,
    input  logic [XLEN-1:0]  src_val_i,
    output logic             trap_o,
    output logic             rd_we_o,
    output logic [XLEN-1:0]  rd_val_o,
    output logic [VL_W-1:0]  vl_o
);

    typedef struct packed {
        logic [VL_W-1:0] vl;
    } vl_state_t;

    vl_state_t       st_d, st_q;
    vl_rule_e        rule;
    logic [VL_W-1:0] vl_new;

    vlset_classify #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W)
    ) u_classify (
        .imm_i      (imm_i),
        .src_zero_i (src_zero_i),
        .src_val_i  (src_val_i),
        .rule_o     (rule)
    );

    vlset_select #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W),
        .VL_W  (VL_W)
    ) u_select (
        .rule_i    (rule),
        .imm_i     (imm_i),
        .src_val_i (src_val_i),
        .vl_new_o  (vl_new)
    );

    always_comb begin
        st_d     = st_q;
        trap_o   = req_valid_i && (rule == RULE_TRAP);
        rd_we_o  = req_valid_i && (rule != RULE_TRAP);
        rd_val_o = '0;
        if (rd_we_o) begin
            st_d.vl  = vl_new;
            rd_val_o = XLEN'(vl_new);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vl_o = st_q.vl;

endmodule

module vlset_unit_chk #(
    parameter int XLEN  = 64,
    parameter int IMM_W = $clog2(XLEN + 2),
    parameter int VL_W  = $clog2(XLEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic [IMM_W-1:0] imm_i,
    input logic             src_zero_i,
    input logic [XLEN-1:0]  src_val_i,
    input logic             trap_o,
    input logic             rd_we_o,
    input logic [XLEN-1:0]  rd_val_o,
    input logic [VL_W-1:0]  vl_o
);

    // R2
    trap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> !rd_we_o);

    // R2
    trap_holds_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> $stable(vl_o));

    // R2
    trap_on_big_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && ({1'b0, imm_i} > (IMM_W+1)'(XLEN))) |-> trap_o);

    // R3
    zero_src_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we_o && src_zero_i) |-> (rd_val_o == XLEN'(imm_i)));

    // R6
    small_src_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we_o && !src_zero_i && (src_val_i <= XLEN'(imm_i))) |-> (rd_val_o == src_val_i));

    // R7
    vl_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |=> (XLEN'(vl_o) == $past(rd_val_o)));

    // R7
    vl_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> (rd_val_o <= XLEN'(XLEN)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |-> (!trap_o && !rd_we_o));

    // R8
    idle_holds_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> $stable(vl_o));

endmodule

bind vlset_unit vlset_unit_chk #(
    .XLEN  (XLEN),
    .IMM_W (IMM_W),
    .VL_W  (VL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .imm_i       (imm_i),
    .src_zero_i  (src_zero_i),
    .src_val_i   (src_val_i),
    .trap_o      (trap_o),
    .rd_we_o     (rd_we_o),
    .rd_val_o    (rd_val_o),
    .vl_o        (vl_o)
);

// File: tb/vlset_unit_tb.sv
module vlset_unit_tb;

    localparam int XLEN     = 64;
    localparam int IMM_W    = $clog2(XLEN + 2);
    localparam int VL_W     = $clog2(XLEN + 1);
    localparam int CLK_PER  = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid_i = 1'b0;
    logic [IMM_W-1:0] imm_i = '0;
    logic             src_zero_i = 1'b0;
    logic [XLEN-1:0]  src_val_i = '0;
    logic             trap_o;
    logic             rd_we_o;
    logic [XLEN-1:0]  rd_val_o;
    logic [VL_W-1:0]  vl_o;

    int checks = 0;
    int errors = 0;
    logic [VL_W-1:0] vl_model = '0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    vlset_unit #(.XLEN(XLEN)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .imm_i       (imm_i),
        .src_zero_i  (src_zero_i),
        .src_val_i   (src_val_i),
        .trap_o      (trap_o),
        .rd_we_o     (rd_we_o),
        .rd_val_o    (rd_val_o),
        .vl_o        (vl_o)
    );

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one request, check same-cycle outputs, then the registered VL.
    task automatic issue(input string req, input int imm, input bit zero,
                         input logic [XLEN-1:0] src, input bit exp_trap,
                         input int exp_vl);
        @(negedge clk);
        req_valid_i = 1'b1;
        imm_i       = IMM_W'(imm);
        src_zero_i  = zero;
        src_val_i   = src;
        #1;
        check({req, " trap"}, XLEN'(trap_o), XLEN'(exp_trap));
        check({req, " we (R7)"}, XLEN'(rd_we_o), XLEN'(!exp_trap));
        if (!exp_trap) begin
            check({req, " rd_val (R7)"}, rd_val_o, XLEN'(exp_vl));
            vl_model = VL_W'(exp_vl);
        end
        @(negedge clk);
        req_valid_i = 1'b0;
        check({req, " vl_o (R7)"}, XLEN'(vl_o), XLEN'(vl_model));
    endtask

    task automatic test_reset();
        #1;
        check("R1 vl after reset", XLEN'(vl_o), '0);
        check("R1 trap idle", XLEN'(trap_o), '0);
        check("R1 we idle", XLEN'(rd_we_o), '0);
    endtask

    task automatic test_zero_src();
        issue("R3 x0 imm=10", 10, 1'b1, 64'd999, 1'b0, 10);
        issue("R3 x0 imm=64", 64, 1'b1, 64'd3, 1'b0, 64);
        issue("R3 x0 imm=0", 0, 1'b1, 64'd7, 1'b0, 0);
    endtask

    task automatic test_full();
        issue("R4 src=17 imm=8", 8, 1'b0, 64'd17, 1'b0, XLEN);
        issue("R6 src=0 imm=0", 0, 1'b0, 64'd0, 1'b0, 0);
        issue("R4 src=max imm=0", 0, 1'b0, {XLEN{1'b1}}, 1'b0, XLEN);
        issue("R4 src=1 imm=0", 0, 1'b0, 64'd1, 1'b0, XLEN);
    endtask

    task automatic test_half();
        issue("R5 src=9 imm=8", 8, 1'b0, 64'd9, 1'b0, 4);
        issue("R5 src=16 imm=8", 8, 1'b0, 64'd16, 1'b0, 8);
        issue("R5 src=15 imm=8", 8, 1'b0, 64'd15, 1'b0, 7);
    endtask

    task automatic test_pass();
        issue("R6 src=5 imm=8", 8, 1'b0, 64'd5, 1'b0, 5);
        issue("R6 src=8 imm=8", 8, 1'b0, 64'd8, 1'b0, 8);
    endtask

    task automatic test_trap();
        issue("R6 setup", 20, 1'b0, 64'd13, 1'b0, 13);
        issue("R2 imm=65", 65, 1'b0, 64'd3, 1'b1, 0);
        issue("R2 imm=127 x0", 127, 1'b1, 64'd3, 1'b1, 0);
        issue("R2 imm=64 legal", 64, 1'b0, 64'd2, 1'b0, 2);
    endtask

    task automatic test_wide_compare();
        issue("R9 src=100 imm=64", 64, 1'b0, 64'd100, 1'b0, 50);
        issue("R9 src=128 imm=64", 64, 1'b0, 64'd128, 1'b0, 64);
        issue("R9 src=129 imm=64", 64, 1'b0, 64'd129, 1'b0, XLEN);
    endtask

    task automatic test_idle();
        issue("R8 setup", 30, 1'b0, 64'd21, 1'b0, 21);
        @(negedge clk);
        imm_i      = IMM_W'(100);
        src_zero_i = 1'b1;
        src_val_i  = 64'd5;
        for (int i = 0; i < 4; i++) begin
            #1;
            check("R8 trap idle", XLEN'(trap_o), '0);
            check("R8 we idle", XLEN'(rd_we_o), '0);
            @(negedge clk);
            check("R8 vl held", XLEN'(vl_o), 64'd21);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_zero_src();
        test_full();
        test_half();
        test_pass();
        test_trap();
        test_wide_compare();
        test_idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule